// File: doc/BRIEF.md
# Startup Configuration Sequencer

This block is the control state machine that brings a device from power-up or a reload request to user operation. Once power-on reset releases, or the active-low program request falls, it tristates user I/O and strobes a clear of configuration memory. It pulls an open-drain init line low while it does so. When the init line reads high it chooses an image source: the on-chip nonvolatile image or an external SPI flash. It then starts a load engine and waits for that engine to report success or failure.

A good load sets the done bit and raises the done pin. A short wake-up phase follows, which ends with I/O released and the device in user mode. A checksum failure stops the sequence with the init line pulled low. If a read from the external source fails and an internal image exists, the load is retried once from the internal image. A self-download strap gives a second mode. In that mode only the internal image is used, the init line and the done pin are left alone, and the program request has no effect.

The flash reader and checksum engine are outside this block and appear only as start, done, CRC-error and read-error signals.

Top module: `boot_seq`

## Requirements
- R1: While `rst_n` is low, `io_hiz` is 1 and `wake`, `done_bit`, `done_pin` and `ld_start` are 0. After `rst_n` rises, `mem_clear` stays high for exactly `CLEAR_CYCLES` rising clock edges.
- R2: Outside self-download mode, a falling edge on `prog_req_n` in any state restarts the sequence. Three clock edges after the pin falls, `mem_clear` is 1, `io_hiz` is 1 and `done_bit` and `wake` are 0.
- R3: Outside self-download mode, `init_drive_low` is 1 during clearing and stays 1 while `prog_req_n` is held low. It is released once `prog_req_n` is high. No load starts while the sensed `init_in` is low.
- R4: With `cfg_sel` = 1 the load source is internal (`src_internal` = 1) when `img_valid` = 1 and external (`src_internal` = 0) when `img_valid` = 0.
- R5: With `cfg_sel` = 0 the load starts from the external source. If that load reports `ld_rd_err` and `img_valid` = 1, one more load starts from the internal source. Without an internal image, a read error halts the sequence with `init_drive_low` = 1, `done_bit` = 0 and `wake` = 0.
- R6: When `ld_done` is seen during a load, `done_bit` is 1 from the next clock edge. `done_pin` follows `done_bit` outside self-download mode.
- R7: `ld_crc_err` during a load halts the sequence, and it wins over a simultaneous `ld_done`. In the halt state `init_drive_low` is 1 (outside self-download mode), `done_bit` is 0, `wake` is 0 and `io_hiz` is 1.
- R8: With `sdm_strap` = 1, `init_drive_low` is never driven. `prog_req_n` is ignored, so a user-mode device stays awake. The load is internal whatever `cfg_sel` is.
- R9: With `sdm_strap` = 1 and `img_valid` = 0, the sequence stalls without starting a load. A one-cycle `refresh_req` pulse restarts it from clearing.
- R10: With `sdm_strap` = 1, `done_pin` stays 0 while `done_bit` is still set on a successful load.
- R11: The wake-up phase lasts `WAKE_CYCLES` clock cycles after the edge that sees `ld_done`. `io_hiz` falls in the last of those cycles, and `wake` rises one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Power-on reset, active low; its release starts a sequence |
| prog_req_n | input | 1 | Asynchronous program request, active low, synchronized inside |
| init_in | input | 1 | Sensed level of the open-drain init line, synchronized inside |
| cfg_sel | input | 1 | Boot select pin: 1 prefers the internal image |
| sdm_strap | input | 1 | Self-download mode strap |
| img_valid | input | 1 | The internal nonvolatile image is programmed |
| refresh_req | input | 1 | One-cycle restart command used out of a self-download stall |
| ld_done | input | 1 | Load engine finished successfully |
| ld_crc_err | input | 1 | Load engine found a checksum error |
| ld_rd_err | input | 1 | Load engine failed to read the source |
| init_drive_low | output | 1 | Pull the init line low |
| io_hiz | output | 1 | Hold user I/O tristated |
| mem_clear | output | 1 | Clear strobe for configuration memory and control state |
| src_internal | output | 1 | Selected source: 1 internal image, 0 external SPI flash |
| ld_start | output | 1 | One-cycle start pulse to the load engine |
| done_bit | output | 1 | Internal configuration-done flag |
| done_pin | output | 1 | Done pin drive |
| wake | output | 1 | Device is in user mode |

## Verification
The hardest case to reach from the ports is a hold-off in which both the program request and an outside agent keep the init line low. The bench first holds `prog_req_n` low, so the block itself keeps driving the line. It then raises `prog_req_n` while an outside hold keeps the line low, and shows that the block lets go of the line but still starts no load until the hold is removed. A bench load responder returns success, a read error or a combined CRC-and-done report, chosen per source. This lets one sequence exercise the external-to-internal retry and the priority of the CRC report.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;

   typedef enum logic [3:0] {
      ST_CLEAR     = 4'd0,
      ST_WAIT_INIT = 4'd1,
      ST_PICK      = 4'd2,
      ST_START     = 4'd3,
      ST_LOAD      = 4'd4,
      ST_WAKE      = 4'd5,
      ST_USER      = 4'd6,
      ST_HALT      = 4'd7,
      ST_STALL     = 4'd8
   } boot_state_t;

   typedef enum logic [1:0] {
      PICK_INT   = 2'd0,
      PICK_EXT   = 2'd1,
      PICK_STALL = 2'd2
   } boot_pick_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/boot_sync.sv
`timescale 1ns/1ps
module boot_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("boot_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/boot_timer.sv
`timescale 1ns/1ps
module boot_timer #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         last
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr || !run)    cnt <= '0;
      else if (!last)          cnt <= cnt + W'(1);
   end

   assign last = run && (cnt == limit);

   // R11
   timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr && $past(run) && !$past(clr)) |-> (cnt <= limit));

endmodule

// File: rtl/boot_src_pick.sv
`timescale 1ns/1ps
module boot_src_pick
   import boot_seq_pkg::*;
#(
   parameter bit FALLBACK_EN = 1'b1
) (
   input  logic       cfg_sel,
   input  logic       img_valid,
   input  logic       sdm,
   input  logic       src_int,
   output boot_pick_t pick,
   output logic       retry_ok
);

   always_comb begin
      if (sdm)                         pick = img_valid ? PICK_INT : PICK_STALL;
      else if (cfg_sel && img_valid)   pick = PICK_INT;
      else                             pick = PICK_EXT;
   end

   generate
      if (FALLBACK_EN) begin : g_fallback
         assign retry_ok = !sdm && img_valid && !src_int;
      end else begin : g_no_fallback
         assign retry_ok = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/boot_seq.sv
`timescale 1ns/1ps
module boot_seq
   import boot_seq_pkg::*;
#(
   parameter int unsigned CLEAR_CYCLES = 8,
   parameter int unsigned WAKE_CYCLES  = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          FALLBACK_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic prog_req_n,
   input  logic init_in,
   input  logic cfg_sel,
   input  logic sdm_strap,
   input  logic img_valid,
   input  logic refresh_req,
   input  logic ld_done,
   input  logic ld_crc_err,
   input  logic ld_rd_err,
   output logic init_drive_low,
   output logic io_hiz,
   output logic mem_clear,
   output logic src_internal,
   output logic ld_start,
   output logic done_bit,
   output logic done_pin,
   output logic wake
);

   localparam int unsigned CW = $clog2(max2(CLEAR_CYCLES, WAKE_CYCLES) + 1);
   localparam logic [CW-1:0] CLR_LIM  = CW'(CLEAR_CYCLES - 1);
   localparam logic [CW-1:0] WAKE_LIM = CW'(WAKE_CYCLES - 1);

   generate
      if (CLEAR_CYCLES < 1) begin : g_bad_clear
         $error("boot_seq: CLEAR_CYCLES must be at least 1");
      end
      if (WAKE_CYCLES < 2) begin : g_bad_wake
         $error("boot_seq: WAKE_CYCLES must be at least 2");
      end
   endgenerate

   boot_state_t st;
   logic        prog_s, prog_q, init_s, prog_fall, restart;
   logic        src_r, done_r;
   logic        tmr_run, tmr_last;
   logic [CW-1:0] tmr_limit;
   boot_pick_t  pick;
   logic        retry_ok;

   boot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_prog_sync (
      .clk(clk), .rst_n(rst_n), .d(prog_req_n), .q(prog_s));

   boot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_init_sync (
      .clk(clk), .rst_n(rst_n), .d(init_in), .q(init_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prog_q <= 1'b1;
      else        prog_q <= prog_s;
   end

   assign prog_fall = prog_q && !prog_s;
   assign restart   = prog_fall && !sdm_strap;

   assign tmr_run   = (st == ST_CLEAR) || (st == ST_WAKE);
   assign tmr_limit = (st == ST_WAKE) ? WAKE_LIM : CLR_LIM;

   boot_timer #(.W(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(restart), .run(tmr_run),
      .limit(tmr_limit), .last(tmr_last));

   boot_src_pick #(.FALLBACK_EN(FALLBACK_EN)) u_pick (
      .cfg_sel(cfg_sel), .img_valid(img_valid), .sdm(sdm_strap),
      .src_int(src_r), .pick(pick), .retry_ok(retry_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_CLEAR;
         src_r  <= 1'b0;
         done_r <= 1'b0;
      end else if (restart) begin
         st     <= ST_CLEAR;
         done_r <= 1'b0;
      end else begin
         unique case (st)
            ST_CLEAR: begin
               done_r <= 1'b0;
               if (tmr_last) st <= sdm_strap ? ST_PICK : ST_WAIT_INIT;
            end
            ST_WAIT_INIT: begin
               if (prog_s && init_s) st <= ST_PICK;
            end
            ST_PICK: begin
               unique case (pick)
                  PICK_INT: begin src_r <= 1'b1; st <= ST_START; end
                  PICK_EXT: begin src_r <= 1'b0; st <= ST_START; end
                  default:  st <= ST_STALL;
               endcase
            end
            ST_START: st <= ST_LOAD;
            ST_LOAD: begin
               if (ld_crc_err) begin
                  st <= ST_HALT;
               end else if (ld_rd_err) begin
                  if (retry_ok) begin
                     src_r <= 1'b1;
                     st    <= ST_START;
                  end else begin
                     st <= ST_HALT;
                  end
               end else if (ld_done) begin
                  done_r <= 1'b1;
                  st     <= ST_WAKE;
               end
            end
            ST_WAKE:  if (tmr_last) st <= ST_USER;
            ST_STALL: if (refresh_req) st <= ST_CLEAR;
            ST_USER, ST_HALT: st <= st;
            default:  st <= ST_CLEAR;
         endcase
      end
   end

   assign init_drive_low = !sdm_strap &&
                           ((st == ST_CLEAR) || (st == ST_HALT) ||
                            ((st == ST_WAIT_INIT) && !prog_s));
   assign io_hiz         = !((st == ST_USER) || ((st == ST_WAKE) && tmr_last));
   assign mem_clear      = (st == ST_CLEAR);
   assign ld_start       = (st == ST_START);
   assign src_internal   = src_r;
   assign done_bit       = done_r;
   assign done_pin       = done_r && !sdm_strap;
   assign wake           = (st == ST_USER);

   // R2
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (mem_clear && !done_bit && io_hiz));

   // R3
   init_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT_INIT && !init_s) |=> !ld_start);

   // R5
   ext_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PICK && !sdm_strap && !cfg_sel && !restart) |=> !src_internal);

   // R6
   wake_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake) |-> done_bit);

   // R7
   crc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOAD && ld_crc_err && !restart) |=> (st == ST_HALT && !done_bit));

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STALL && !refresh_req && !restart) |=> (st == ST_STALL && !ld_start));

endmodule

// File: tb/tb_boot_seq.sv
`timescale 1ns/1ps
module tb_boot_seq;

   localparam int CLR = 8;
   localparam int WK  = 4;
   localparam int RES_DONE = 0;
   localparam int RES_CRC  = 1;
   localparam int RES_RD   = 2;

   logic clk = 1'b0;
   logic rst_n, prog_req_n, cfg_sel, sdm_strap, img_valid, refresh_req;
   logic ld_done, ld_crc_err, ld_rd_err, ext_hold;
   logic init_line;
   logic init_drive_low, io_hiz, mem_clear, src_internal, ld_start;
   logic done_bit, done_pin, wake;

   int checks = 0;
   int errors = 0;
   int starts = 0;
   int ext_res = RES_DONE;
   int int_res = RES_DONE;
   int resp_sel = RES_DONE;
   bit init_seen = 1'b0;
   bit exp_q[$];
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   assign init_line = ~(init_drive_low | ext_hold);

   boot_seq #(.CLEAR_CYCLES(CLR), .WAKE_CYCLES(WK)) dut (
      .clk(clk), .rst_n(rst_n), .prog_req_n(prog_req_n), .init_in(init_line),
      .cfg_sel(cfg_sel), .sdm_strap(sdm_strap), .img_valid(img_valid),
      .refresh_req(refresh_req), .ld_done(ld_done), .ld_crc_err(ld_crc_err),
      .ld_rd_err(ld_rd_err), .init_drive_low(init_drive_low), .io_hiz(io_hiz),
      .mem_clear(mem_clear), .src_internal(src_internal), .ld_start(ld_start),
      .done_bit(done_bit), .done_pin(done_pin), .wake(wake));

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Scoreboard monitor: each load start pops the expected source
   initial begin
      forever begin
         @(negedge clk);
         if (init_drive_low) init_seen = 1'b1;
         if (ld_start) begin
            starts++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 R5 unexpected load start", 1, 0);
            end else begin
               bit e;
               e = exp_q.pop_front();
               chk(src_internal == e, "R4 R5 R8 load source", int'(src_internal), int'(e));
            end
         end
      end
   end

   // Load engine model, with done-bit and wake-up timing checks
   initial begin
      ld_done = 1'b0; ld_crc_err = 1'b0; ld_rd_err = 1'b0;
      forever begin
         @(negedge clk);
         while (ld_start) begin
            resp_sel = src_internal ? int_res : ext_res;
            repeat (3) @(negedge clk);
            if (resp_sel == RES_DONE)     ld_done = 1'b1;
            else if (resp_sel == RES_CRC) begin ld_crc_err = 1'b1; ld_done = 1'b1; end
            else                          ld_rd_err = 1'b1;
            @(negedge clk);
            ld_done = 1'b0; ld_crc_err = 1'b0; ld_rd_err = 1'b0;
            if (resp_sel == RES_DONE) begin
               chk(done_bit == 1'b1, "R6 done bit one edge after ld_done", int'(done_bit), 1);
               repeat (WK - 2) @(negedge clk);
               chk(io_hiz == 1'b1 && wake == 1'b0, "R11 io still tristated before last wake cycle",
                   int'(io_hiz), 1);
               @(negedge clk);
               chk(io_hiz == 1'b0 && wake == 1'b0, "R11 io released in last wake cycle",
                   int'(io_hiz), 0);
               @(negedge clk);
               chk(wake == 1'b1, "R11 wake after wake phase", int'(wake), 1);
            end
         end
      end
   end

   task automatic por();
      int n;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(io_hiz == 1'b1, "R1 io tristated in reset", int'(io_hiz), 1);
      chk({wake, done_bit, done_pin, ld_start} == 4'b0, "R1 outputs low in reset",
          int'({wake, done_bit, done_pin, ld_start}), 0);
      rst_n = 1'b1;
      n = 0;
      for (int i = 0; i < 4 * CLR; i++) begin
         @(negedge clk);
         if (mem_clear) n++;
         else break;
      end
      // strobe covers CLR edges: CLR-1 negedges fall after the first of them
      chk(n == CLR - 1, "R1 clear strobe length", n, CLR - 1);
   endtask

   task automatic pulse_prog();
      prog_req_n = 1'b0;
      repeat (4) @(negedge clk);
      prog_req_n = 1'b1;
   endtask

   task automatic wait_wake(input int lim, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (wake) begin ok = 1'b1; break; end
      end
   endtask

   initial begin
      bit ok;
      int s0;
      rst_n = 1'b0; prog_req_n = 1'b1; cfg_sel = 1'b1; sdm_strap = 1'b0;
      img_valid = 1'b1; refresh_req = 1'b0; ext_hold = 1'b0;

      // internal boot with select high and image present
      exp_q.push_back(1'b1);
      por();
      wait_wake(200, ok);
      chk(ok, "R4 internal boot reaches user mode", int'(ok), 1);
      chk(done_pin == 1'b1, "R6 done pin high", int'(done_pin), 1);
      repeat (2) @(negedge clk);

      // select high, image absent: external
      img_valid = 1'b0;
      exp_q.push_back(1'b0);
      pulse_prog();
      wait_wake(200, ok);
      chk(ok, "R4 external boot reaches user mode", int'(ok), 1);

      // select low, external read error, retry internal
      cfg_sel = 1'b0; img_valid = 1'b1; ext_res = RES_RD; int_res = RES_DONE;
      exp_q.push_back(1'b0);
      exp_q.push_back(1'b1);
      pulse_prog();
      wait_wake(300, ok);
      chk(ok, "R5 fallback to internal image", int'(ok), 1);
      chk(exp_q.size() == 0, "R5 both loads started", exp_q.size(), 0);

      // read error with no internal image: halt
      img_valid = 1'b0;
      exp_q.push_back(1'b0);
      pulse_prog();
      repeat (60) @(negedge clk);
      chk(wake == 1'b0 && done_bit == 1'b0, "R5 halt after read error", int'(wake), 0);
      chk(init_drive_low == 1'b1, "R5 init pulled low in halt", int'(init_drive_low), 1);

      // CRC with simultaneous done: halt, done stays clear
      cfg_sel = 1'b1; img_valid = 1'b1; int_res = RES_CRC;
      exp_q.push_back(1'b1);
      pulse_prog();
      repeat (60) @(negedge clk);
      chk(done_bit == 1'b0 && done_pin == 1'b0, "R7 done clear after CRC error", int'(done_bit), 0);
      chk(wake == 1'b0 && io_hiz == 1'b1, "R7 no wake after CRC error", int'(wake), 0);
      chk(init_drive_low == 1'b1, "R7 init pulled low after CRC error", int'(init_drive_low), 1);

      // init hold-off: program request held, then outside hold
      int_res = RES_DONE;
      s0 = starts;
      prog_req_n = 1'b0;
      repeat (30) @(negedge clk);
      chk(init_drive_low == 1'b1, "R3 init driven while program request low", int'(init_drive_low), 1);
      ext_hold = 1'b1;
      prog_req_n = 1'b1;
      repeat (30) @(negedge clk);
      chk(init_drive_low == 1'b0, "R3 init released with program request high", int'(init_drive_low), 0);
      chk(starts == s0, "R3 no load while init line held low", starts - s0, 0);
      exp_q.push_back(1'b1);
      ext_hold = 1'b0;
      wait_wake(200, ok);
      chk(ok, "R3 boot proceeds after hold removed", int'(ok), 1);

      // program request falling edge from user mode
      prog_req_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(mem_clear == 1'b1 && io_hiz == 1'b1, "R2 restart clears and tristates", int'(mem_clear), 1);
      chk(done_bit == 1'b0 && wake == 1'b0, "R2 restart drops done and wake", int'(done_bit), 0);
      exp_q.push_back(1'b1);
      prog_req_n = 1'b1;
      wait_wake(200, ok);
      chk(ok, "R2 reboot after restart", int'(ok), 1);

      // self-download mode, select ignored
      sdm_strap = 1'b1; cfg_sel = 1'b0; img_valid = 1'b1;
      exp_q.push_back(1'b1);
      init_seen = 1'b0;
      por();
      wait_wake(200, ok);
      chk(ok, "R8 self-download boot reaches user mode", int'(ok), 1);
      chk(done_bit == 1'b1 && done_pin == 1'b0, "R10 done bit set, pin idle", int'(done_pin), 0);
      chk(init_seen == 1'b0, "R8 init line never driven", int'(init_seen), 0);
      prog_req_n = 1'b0;
      repeat (8) @(negedge clk);
      chk(wake == 1'b1 && done_bit == 1'b1, "R8 program request ignored", int'(wake), 1);
      prog_req_n = 1'b1;

      // self-download mode without image: stall, then refresh
      img_valid = 1'b0;
      por();
      s0 = starts;
      repeat (40) @(negedge clk);
      chk(wake == 1'b0 && starts == s0, "R9 stall without image", starts - s0, 0);
      img_valid = 1'b1;
      exp_q.push_back(1'b1);
      refresh_req = 1'b1;
      @(negedge clk);
      refresh_req = 1'b0;
      wait_wake(200, ok);
      chk(ok, "R9 refresh restarts sequence", int'(ok), 1);
      chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

      repeat (4) @(negedge clk);
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
   end

endmodule